// File: doc/BRIEF.md
# Dual-Mode Fractional Rate Generator

This block derives a rate-reduced clock-enable strobe from one of four source tick strobes, all in a single system clock domain. A small write-only configuration register holds a 2-bit source select, a mode bit and a 6-bit phase value N. In fractional mode the output rate is a fraction N/26 of the selected source, produced by a modulo-26 rate accumulator. N of zero bypasses the divider. In integer mode the source is divided by N+1.

The divided strobe passes through an active-high kill input and then feeds two separately enabled gated outputs. These are meant for two consumers that share the derived rate but can each be switched off. Every output is registered and appears one system clock after the source tick that caused it.

Top module: `clk_rate_gen`

## Requirements
- R1: `cfg_src_sel` picks the source tick: 0 = `src_ticks[0]` (primary crystal), 1 = `src_ticks[1]` (PLL), 2 = `src_ticks[2]` (secondary crystal), 3 = `src_ticks[3]` (PLL divider); ticks on the unselected bits have no effect on any output.
- R2: Synchronous active-high `rst` clears select, mode and N to 0 and drives all outputs low; after reset with no write, `div_tick` follows `src_ticks[0]` one-for-one.
- R3: With `cfg_int_mode`=0 and N=0, each selected source tick produces `div_tick` high exactly one clock later.
- R4: With `cfg_int_mode`=0 and 1 <= N <= 26, an accumulator adds N per source tick and emits a tick when the sum reaches 26 (then subtracting 26); W source ticks after a write give floor(W*N/26) output ticks, the first on source tick ceil(26/N).
- R5: With `cfg_int_mode`=0 and 27 <= N <= 32, every selected source tick produces an output tick.
- R6: With `cfg_int_mode`=0 and N > 32, no output tick is ever produced.
- R7: With `cfg_int_mode`=1, output ticks occur on source ticks N+1, 2(N+1), ... after a write, so W source ticks give floor(W/(N+1)) ticks, for every N from 0 to 63.
- R8: A cycle with `cfg_we` high loads all three fields, restarts the accumulator and the integer counter, and drops any source tick arriving in that same cycle.
- R9: When `out_disable` is high in the cycle of a source tick, `div_tick`, `gated_a_tick` and `gated_b_tick` all stay low for it.
- R10: `gated_a_tick` equals `div_tick` when `gate_a_en` was high in the source-tick cycle and is low otherwise; `gated_b_tick` behaves likewise with `gate_b_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ticks | input | 4 | One-cycle tick strobes of the four candidate sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src_sel | input | 2 | Source select written on `cfg_we` |
| cfg_int_mode | input | 1 | 0 = fractional N/26, 1 = integer divide by N+1 |
| cfg_phase | input | 6 | Phase value N written on `cfg_we` |
| out_disable | input | 1 | Active-high kill of all outputs |
| gate_a_en | input | 1 | Enable of gated output A |
| gate_b_en | input | 1 | Enable of gated output B |
| div_tick | output | 1 | Divided tick strobe |
| gated_a_tick | output | 1 | Divided tick gated by `gate_a_en` |
| gated_b_tick | output | 1 | Divided tick gated by `gate_b_en` |

## Verification
The assertions assume `rst` is held high across the first clock edge. They also assume that a configuration takes effect only through `cfg_we`, so the registered select, mode and N can be trusted as the setting in force. The bench releases reset only after several edges and changes configuration solely through single-cycle writes. It holds `src_ticks` for exactly one cycle per pulse, while the unselected bits are strobed on every cycle to exercise R1.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;

    localparam int SRC_SEL_W = 2;
    localparam int PHASE_W   = 6;

    typedef enum logic {
        DIV_FRAC = 1'b0,
        DIV_INT  = 1'b1
    } div_mode_e;

    typedef enum logic [1:0] {
        FK_BYPASS,
        FK_ACCUM,
        FK_SATURATE,
        FK_MUTE
    } frac_kind_e;

    typedef struct packed {
        logic [SRC_SEL_W-1:0] sel;
        div_mode_e            mode;
        logic [PHASE_W-1:0]   phase;
    } rate_cfg_t;

    // Sort a phase value into the fractional-mode behaviour it selects.
    function automatic frac_kind_e frac_classify(
        input logic [PHASE_W-1:0] phase,
        input int                 denom,
        input int                 limit
    );
        int p;
        p = int'(phase);
        if (p == 0)
            return FK_BYPASS;
        else if (p <= denom)
            return FK_ACCUM;
        else if (p <= limit)
            return FK_SATURATE;
        else
            return FK_MUTE;
    endfunction

endpackage

// File: rtl/crg_cfg_reg.sv
module crg_cfg_reg
    import clk_rate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SRC_SEL_W-1:0] sel_in,
    input  logic                 mode_in,
    input  logic [PHASE_W-1:0]   phase_in,
    output rate_cfg_t            cfg_q,
    output logic                 restart
);

    rate_cfg_t cfg_next;

    always_comb begin
        cfg_next.sel   = sel_in;
        cfg_next.mode  = div_mode_e'(mode_in);
        cfg_next.phase = phase_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (we)
            cfg_q <= cfg_next;
    end

    // A write restarts the rate state in the same edge that loads the fields.
    assign restart = we;

endmodule

// File: rtl/crg_src_mux.sv
module crg_src_mux #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               sel_tick
);

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(sel) == i)
                sel_tick = ticks[i];
        end
    end

endmodule

// File: rtl/crg_frac_accum.sv
module crg_frac_accum
    import clk_rate_pkg::*;
#(
    parameter int DENOM      = 26,
    parameter int FRAC_LIMIT = 32,
    localparam int ACC_W     = $clog2(2 * DENOM),
    localparam int SUM_W     = ACC_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               enable,
    input  logic               tick_in,
    input  logic [PHASE_W-1:0] phase,
    output logic               tick_out,
    output logic [ACC_W-1:0]   level
);

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic             carry;
    frac_kind_e       kind;
    logic             step;

    assign kind  = frac_classify(phase, DENOM, FRAC_LIMIT);
    assign sum   = SUM_W'(acc_q) + SUM_W'(phase);
    assign carry = (sum >= SUM_W'(DENOM));
    assign step  = enable && !clear && tick_in;

    always_comb begin
        unique case (kind)
            FK_BYPASS:   tick_out = step;
            FK_ACCUM:    tick_out = step && carry;
            FK_SATURATE: tick_out = step;
            default:     tick_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (step && kind == FK_ACCUM) begin
            if (carry)
                acc_q <= ACC_W'(sum - SUM_W'(DENOM));
            else
                acc_q <= ACC_W'(sum);
        end
    end

    assign level = acc_q;

endmodule

// File: rtl/crg_int_div.sv
module crg_int_div
    import clk_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               enable,
    input  logic               tick_in,
    input  logic [PHASE_W-1:0] phase,
    output logic               tick_out
);

    logic [PHASE_W-1:0] cnt_q;
    logic               step;
    logic               hit;

    assign step     = enable && !clear && tick_in;
    assign hit      = (cnt_q == phase);
    assign tick_out = step && hit;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/crg_out_stage.sv
module crg_out_stage #(
    parameter int NUM_GATES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raw_tick,
    input  logic                 kill,
    input  logic [NUM_GATES-1:0] gate_en,
    output logic                 div_q,
    output logic [NUM_GATES-1:0] gated_q
);

    logic live;

    assign live = raw_tick && !kill;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= 1'b0;
        else
            div_q <= live;
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        always_ff @(posedge clk) begin
            if (rst)
                gated_q[g] <= 1'b0;
            else
                gated_q[g] <= live && gate_en[g];
        end
    end

endmodule

// File: rtl/clk_rate_gen.sv
module clk_rate_gen
    import clk_rate_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int DENOM      = 26,
    parameter int FRAC_LIMIT = 32,
    localparam int ACC_W     = $clog2(2 * DENOM),
    localparam int NUM_GATES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_ticks,
    input  logic                 cfg_we,
    input  logic [SRC_SEL_W-1:0] cfg_src_sel,
    input  logic                 cfg_int_mode,
    input  logic [PHASE_W-1:0]   cfg_phase,
    input  logic                 out_disable,
    input  logic                 gate_a_en,
    input  logic                 gate_b_en,
    output logic                 div_tick,
    output logic                 gated_a_tick,
    output logic                 gated_b_tick
);

    rate_cfg_t              cfg_q;
    logic                   restart;
    logic                   sel_tick;
    logic                   frac_tick;
    logic                   int_tick;
    logic                   raw_tick;
    logic [ACC_W-1:0]       frac_level;
    logic [SRC_SEL_W-1:0]   act_sel;
    logic                   act_int_mode;
    logic [PHASE_W-1:0]     act_phase;
    logic [NUM_GATES-1:0]   gate_vec;
    logic [NUM_GATES-1:0]   gated_vec;

    assign act_sel      = cfg_q.sel;
    assign act_int_mode = (cfg_q.mode == DIV_INT);
    assign act_phase    = cfg_q.phase;
    assign gate_vec     = {gate_b_en, gate_a_en};

    crg_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel_in   (cfg_src_sel),
        .mode_in  (cfg_int_mode),
        .phase_in (cfg_phase),
        .cfg_q    (cfg_q),
        .restart  (restart)
    );

    crg_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
        .ticks    (src_ticks),
        .sel      (act_sel),
        .sel_tick (sel_tick)
    );

    crg_frac_accum #(.DENOM(DENOM), .FRAC_LIMIT(FRAC_LIMIT)) u_frac (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .enable   (!act_int_mode),
        .tick_in  (sel_tick),
        .phase    (act_phase),
        .tick_out (frac_tick),
        .level    (frac_level)
    );

    crg_int_div u_int (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .enable   (act_int_mode),
        .tick_in  (sel_tick),
        .phase    (act_phase),
        .tick_out (int_tick)
    );

    assign raw_tick = act_int_mode ? int_tick : frac_tick;

    crg_out_stage #(.NUM_GATES(NUM_GATES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .raw_tick (raw_tick),
        .kill     (out_disable),
        .gate_en  (gate_vec),
        .div_q    (div_tick),
        .gated_q  (gated_vec)
    );

    assign gated_a_tick = gated_vec[0];
    assign gated_b_tick = gated_vec[1];

endmodule

// File: rtl/clk_rate_gen_chk.sv
module clk_rate_gen_chk
    import clk_rate_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int DENOM      = 26,
    parameter int FRAC_LIMIT = 32,
    localparam int ACC_W     = $clog2(2 * DENOM)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_SRC-1:0]   src_ticks,
    input logic                 cfg_we,
    input logic                 out_disable,
    input logic                 gate_a_en,
    input logic                 gate_b_en,
    input logic                 div_tick,
    input logic                 gated_a_tick,
    input logic                 gated_b_tick,
    input logic [SRC_SEL_W-1:0] act_sel,
    input logic                 act_int_mode,
    input logic [PHASE_W-1:0]   act_phase,
    input logic [ACC_W-1:0]     frac_level
);

    // R1 R8 R9
    tick_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> $past(src_ticks[act_sel] && !cfg_we && !out_disable));

    // R3
    bypass_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_int_mode && act_phase == '0 && src_ticks[act_sel] && !cfg_we && !out_disable)
        |=> div_tick);

    // R4
    accum_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        int'(frac_level) < DENOM);

    // R6
    undefined_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_int_mode && int'(act_phase) > FRAC_LIMIT) |=> !div_tick);

    // R7
    int_unity_chk: assert property (@(posedge clk) disable iff (rst)
        (act_int_mode && act_phase == '0 && src_ticks[act_sel] && !cfg_we && !out_disable)
        |=> div_tick);

    // R9
    kill_all_chk: assert property (@(posedge clk) disable iff (rst)
        out_disable |=> !(div_tick || gated_a_tick || gated_b_tick));

    // R10
    gate_a_off_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_a_en |=> !gated_a_tick);

    // R10
    gate_b_off_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_b_en |=> !gated_b_tick);

    // R10
    gated_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (gated_a_tick || gated_b_tick) |-> div_tick);

endmodule

bind clk_rate_gen clk_rate_gen_chk #(
    .NUM_SRC(NUM_SRC), .DENOM(DENOM), .FRAC_LIMIT(FRAC_LIMIT)
) u_chk (.*);

// File: tb/clk_rate_gen_bench.sv
`timescale 1ns/1ps
module clk_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_ticks = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_src_sel = '0;
    logic       cfg_int_mode = 1'b0;
    logic [5:0] cfg_phase = '0;
    logic       out_disable = 1'b0;
    logic       gate_a_en = 1'b0;
    logic       gate_b_en = 1'b0;
    logic       div_tick, gated_a_tick, gated_b_tick;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clk_rate_gen u_clk_rate_gen (
        .clk(clk), .rst(rst), .src_ticks(src_ticks), .cfg_we(cfg_we),
        .cfg_src_sel(cfg_src_sel), .cfg_int_mode(cfg_int_mode), .cfg_phase(cfg_phase),
        .out_disable(out_disable), .gate_a_en(gate_a_en), .gate_b_en(gate_b_en),
        .div_tick(div_tick), .gated_a_tick(gated_a_tick), .gated_b_tick(gated_b_tick)
    );

    localparam int NV = 14;
    localparam int T_SEL  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3, 0, 1};
    localparam int T_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
    localparam int T_N    [NV] = '{0, 1, 13, 26, 32, 63, 5, 7, 0, 1, 13, 63, 26, 27};
    localparam int T_W    [NV] = '{20, 52, 52, 30, 30, 30, 52, 40, 20, 20, 42, 130, 54, 25};

    function automatic int exp_cnt(int mode, int n, int w);
        if (mode == 1) return w / (n + 1);
        if (n == 0)    return w;
        if (n <= 26)   return (w * n) / 26;
        if (n <= 32)   return w;
        return 0;
    endfunction

    function automatic string req_of(int mode, int n);
        if (mode == 1) return "R7";
        if (n == 0)    return "R3";
        if (n <= 26)   return "R4";
        if (n <= 32)   return "R5";
        return "R6";
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(int sel, int mode, int n, logic [3:0] s);
        @(negedge clk);
        cfg_src_sel = 2'(sel); cfg_int_mode = mode[0]; cfg_phase = 6'(n);
        cfg_we = 1'b1; src_ticks = s;
        @(negedge clk);
        cfg_we = 1'b0; src_ticks = '0;
    endtask

    task automatic pulse(logic [3:0] s);
        @(negedge clk);
        src_ticks = s;
        @(negedge clk);
        src_ticks = '0;
    endtask

    task automatic run_window(int sel, int mode, int n, int w);
        int cd = 0, ca = 0, cb = 0;
        logic [3:0] selbit, noise;
        selbit = 4'(1 << sel);
        noise  = ~selbit;
        @(negedge clk);
        cfg_src_sel = 2'(sel); cfg_int_mode = mode[0]; cfg_phase = 6'(n);
        cfg_we = 1'b1; src_ticks = 4'hF;
        gate_a_en = 1'b1; gate_b_en = 1'b0; out_disable = 1'b0;
        for (int i = 0; i < 2 * w; i++) begin
            @(negedge clk);
            cd += int'(div_tick); ca += int'(gated_a_tick); cb += int'(gated_b_tick);
            cfg_we = 1'b0;
            src_ticks = noise | ((i % 2 == 0) ? selbit : 4'b0);
        end
        @(negedge clk);
        cd += int'(div_tick); ca += int'(gated_a_tick); cb += int'(gated_b_tick);
        src_ticks = '0;
        // R1: noise on unselected sources must not change the count
        check(cd == exp_cnt(mode, n, w), {req_of(mode, n), " R1 count"}, cd, exp_cnt(mode, n, w));
        check(ca == cd, "R10 gate A open", ca, cd);
        check(cb == 0, "R10 gate B closed", cb, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        // R2: reset state
        check(div_tick == 1'b0, "R2 reset div", int'(div_tick), 0);
        check(gated_a_tick == 1'b0, "R2 reset gate A", int'(gated_a_tick), 0);
        check(gated_b_tick == 1'b0, "R2 reset gate B", int'(gated_b_tick), 0);
        rst = 1'b0;
        gate_a_en = 1'b1;

        // R1: unselected source after reset is ignored
        pulse(4'b0010);
        check(div_tick == 1'b0, "R1 unselected source", int'(div_tick), 0);
        // R2 R3: default config passes source 0 through
        pulse(4'b0001);
        check(div_tick == 1'b1, "R2 default passthrough", int'(div_tick), 1);
        check(gated_a_tick == 1'b1, "R10 gate A follows", int'(gated_a_tick), 1);

        // R9: kill suppresses all outputs
        out_disable = 1'b1; gate_b_en = 1'b1;
        pulse(4'b0001);
        check(div_tick == 1'b0, "R9 disable div", int'(div_tick), 0);
        check(gated_b_tick == 1'b0, "R9 disable gate B", int'(gated_b_tick), 0);
        out_disable = 1'b0;

        // R10: gate B alone
        gate_a_en = 1'b0;
        pulse(4'b0001);
        check(gated_b_tick == 1'b1, "R10 gate B on", int'(gated_b_tick), 1);
        check(gated_a_tick == 1'b0, "R10 gate A off", int'(gated_a_tick), 0);
        gate_a_en = 1'b1; gate_b_en = 1'b0;

        // R8: source tick in the write cycle is dropped
        write_cfg(0, 0, 0, 4'b0001);
        check(div_tick == 1'b0, "R8 write-cycle tick dropped", int'(div_tick), 0);

        // R4: N=13 first tick on second source tick
        write_cfg(2, 0, 13, 4'b0000);
        pulse(4'b0100);
        check(div_tick == 1'b0, "R4 N13 first source tick", int'(div_tick), 0);
        pulse(4'b0100);
        check(div_tick == 1'b1, "R4 N13 second source tick", int'(div_tick), 1);

        // R8: rewrite restarts a partly filled accumulator
        write_cfg(0, 0, 1, 4'b0000);
        cnt = 0;
        for (int i = 0; i < 25; i++) begin pulse(4'b0001); cnt += int'(div_tick); end
        write_cfg(0, 0, 1, 4'b0000);
        for (int i = 0; i < 25; i++) begin pulse(4'b0001); cnt += int'(div_tick); end
        check(cnt == 0, "R8 accumulator restart", cnt, 0);
        pulse(4'b0001);
        check(div_tick == 1'b1, "R8 N1 tick after 26", int'(div_tick), 1);

        // R7: integer divide by 4 fires on fourth source tick
        write_cfg(3, 1, 3, 4'b0000);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin pulse(4'b1000); cnt += int'(div_tick); end
        check(cnt == 0, "R7 N3 no early tick", cnt, 0);
        pulse(4'b1000);
        check(div_tick == 1'b1, "R7 N3 fourth tick", int'(div_tick), 1);

        // Rate table: R1 R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++)
            run_window(T_SEL[v], T_MODE[v], T_N[v], T_W[v]);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule